// File: doc/BRIEF.md
# Reset-Time Configuration Identity Loader

After reset is released, this block reads three 16-bit words from a non-volatile store through a simple word-read port. The words sit at addresses 0xA, 0xB and 0xC, and the block issues one request at a time. The first word is a control word. Its top two bits form a presence signature, and bit 13 is a mode bit. Together they decide whether the subsystem identifiers and the low bits of the revision identifier are taken from the store or stay at their defaults.

The block drives the read-only identity fields of a configuration register space. These are the device ID, the vendor ID, the revision ID, the subsystem ID, the subsystem vendor ID and a fixed capability pointer. Until the third word has been processed, the block tells the configuration-access front end to answer every access with Retry. All loaded values are applied at once, on the same clock edge that raises the done flag.

Top module: `cfg_id_loader`

## Requirements
- R1: Read requests go to word addresses 0xA, 0xB and 0xC, in that order, and each address is requested exactly once per reset.
- R2: `rd_req` is high for one cycle per request. No new request is raised until `rd_valid` has answered the previous one. No request is raised after loading completes.
- R3: `cfg_retry` is high from reset release until loading completes. It is low from then on.
- R4: `load_done` rises on the clock edge that accepts the third response. It stays high until the next reset.
- R5: If bits [15:14] of word 0xA are not 2'b01, the subsystem ID and subsystem vendor ID stay 16'h0000 and the revision ID stays 8'h09.
- R6: If bits [15:14] of word 0xA equal 2'b01, the subsystem ID takes word 0xB and the subsystem vendor ID takes word 0xC.
- R7: If bits [15:14] of word 0xA equal 2'b01 and bit 13 is 1, the revision ID becomes {5'b00001, word 0xA bits [10:8]}. If bit 13 is 0, the revision ID stays 8'h09.
- R8: The device ID reads 16'h1209, the vendor ID reads the fixed parameter value (default 16'h5A5A) and the capability pointer reads 8'hDC. These values hold at all times.
- R9: After completion, `ctrl_word` shows word 0xA whatever its signature bits hold. Before completion it reads 16'h0000.
- R10: Before `load_done` is high, the subsystem fields and the revision ID show their defaults. No partially loaded value is visible.
- R11: A `rd_valid` pulse with no read pending has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | output | 1 | One-cycle word read request |
| rd_addr | output | 8 | Word address of the request |
| rd_valid | input | 1 | Response data valid pulse |
| rd_data | input | 16 | Response word |
| cfg_retry | output | 1 | Front end must answer configuration accesses with Retry |
| load_done | output | 1 | Loading complete (sticky until reset) |
| ctrl_word | output | 16 | Registered control word (address 0xA) |
| device_id | output | 16 | Fixed device identifier |
| vendor_id | output | 16 | Fixed vendor identifier |
| revision_id | output | 8 | Revision identifier |
| subsys_id | output | 16 | Subsystem identifier |
| subsys_vendor_id | output | 16 | Subsystem vendor identifier |
| cap_ptr | output | 8 | Fixed capability pointer |

## Verification
The assertions check the following on every cycle:
- the done flag stays high once it is set;
- requests are single pulses, and none is raised after completion;
- Retry is held until completion;
- the identity fields keep their defaults before completion and never change after it.

Some behaviour only the bench scenarios can show. These are the address order, the decoding of every signature and mode combination with every loaded revision value, the control-word exposure, and the immunity to stray responses. The bench checks these by sweeping all of them against a memory model with varying response latency.

// File: rtl/cfg_id_pkg.sv
package cfg_id_pkg;
   localparam int unsigned WORD_W    = 16;
   localparam int unsigned NUM_WORDS = 3;
   localparam logic [1:0]  SIG_OK    = 2'b01;

   typedef enum logic [1:0] {
      LD_REQ  = 2'd0,
      LD_WAIT = 2'd1,
      LD_DONE = 2'd2
   } ld_state_t;

   function automatic logic store_present(input logic [WORD_W-1:0] w);
      return w[15:14] == SIG_OK;
   endfunction
endpackage

// File: rtl/id_fetch_seq.sv
module id_fetch_seq
   import cfg_id_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0A
) (
   input  logic                          clk,
   input  logic                          rst_n,
   output logic                          rd_req,
   output logic [ADDR_W-1:0]             rd_addr,
   input  logic                          rd_valid,
   input  logic [WORD_W-1:0]             rd_data,
   output logic [NUM_WORDS*WORD_W-1:0]   words,
   output logic                          commit
);
   localparam int unsigned IDX_W = $clog2(NUM_WORDS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

   ld_state_t            state_q;
   logic [IDX_W-1:0]     idx_q;
   logic [WORD_W-1:0]    buf_q [NUM_WORDS-1];
   logic                 take;

   assign take    = (state_q == LD_WAIT) && rd_valid;
   assign commit  = take && (idx_q == LAST);
   assign rd_req  = (state_q == LD_REQ);
   assign rd_addr = BASE_ADDR + ADDR_W'(idx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_REQ;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            LD_REQ:  state_q <= LD_WAIT;
            LD_WAIT: if (take) begin
               if (idx_q == LAST) begin
                  state_q <= LD_DONE;
               end else begin
                  state_q <= LD_REQ;
                  idx_q   <= idx_q + 1'b1;
               end
            end
            default: state_q <= LD_DONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS - 1; i++) buf_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_WORDS - 1; i++)
            if (take && idx_q == IDX_W'(i)) buf_q[i] <= rd_data;
      end
   end

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_words
      if (g == NUM_WORDS - 1) begin : g_live
         assign words[g*WORD_W +: WORD_W] = rd_data;
      end else begin : g_held
         assign words[g*WORD_W +: WORD_W] = buf_q[g];
      end
   end
endmodule

// File: rtl/id_decode.sv
module id_decode
   import cfg_id_pkg::*;
#(
   parameter logic [7:0]  DEF_REV    = 8'h09,
   parameter int unsigned REV_LOAD_W = 3,
   parameter int unsigned REV_SRC_LSB = 8
) (
   input  logic [NUM_WORDS*WORD_W-1:0] words,
   output logic [WORD_W-1:0]           ctrl,
   output logic [WORD_W-1:0]           sub_id,
   output logic [WORD_W-1:0]           sub_ven,
   output logic [7:0]                  rev
);
   logic present;

   assign ctrl    = words[0 +: WORD_W];
   assign present = store_present(ctrl);
   assign sub_id  = present ? words[WORD_W +: WORD_W]   : '0;
   assign sub_ven = present ? words[2*WORD_W +: WORD_W] : '0;

   if (REV_LOAD_W == 0) begin : g_rev_fixed
      assign rev = DEF_REV;
   end else if (REV_LOAD_W >= 8) begin : g_rev_full
      assign rev = (present && ctrl[13]) ? ctrl[REV_SRC_LSB +: 8] : DEF_REV;
   end else begin : g_rev_low
      assign rev = (present && ctrl[13])
                   ? {DEF_REV[7:REV_LOAD_W], ctrl[REV_SRC_LSB +: REV_LOAD_W]}
                   : DEF_REV;
   end
endmodule

// File: rtl/id_regs.sv
module id_regs
   import cfg_id_pkg::*;
#(
   parameter logic [7:0] DEF_REV = 8'h09
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [WORD_W-1:0] ctrl_d,
   input  logic [WORD_W-1:0] sub_id_d,
   input  logic [WORD_W-1:0] sub_ven_d,
   input  logic [7:0]        rev_d,
   output logic [WORD_W-1:0] ctrl_q,
   output logic [WORD_W-1:0] sub_id_q,
   output logic [WORD_W-1:0] sub_ven_q,
   output logic [7:0]        rev_q,
   output logic              done_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         sub_id_q  <= '0;
         sub_ven_q <= '0;
         rev_q     <= DEF_REV;
         done_q    <= 1'b0;
      end else if (commit && !done_q) begin
         ctrl_q    <= ctrl_d;
         sub_id_q  <= sub_id_d;
         sub_ven_q <= sub_ven_d;
         rev_q     <= rev_d;
         done_q    <= 1'b1;
      end
   end
endmodule

// File: rtl/cfg_id_loader.sv
module cfg_id_loader
   import cfg_id_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h0A,
   parameter logic [15:0]       DEVICE_ID  = 16'h1209,
   parameter logic [15:0]       VENDOR_ID  = 16'h5A5A,
   parameter logic [7:0]        DEF_REV    = 8'h09,
   parameter logic [7:0]        CAP_PTR    = 8'hDC,
   parameter int unsigned       REV_LOAD_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [15:0]       rd_data,
   output logic              cfg_retry,
   output logic              load_done,
   output logic [15:0]       ctrl_word,
   output logic [15:0]       device_id,
   output logic [15:0]       vendor_id,
   output logic [7:0]        revision_id,
   output logic [15:0]       subsys_id,
   output logic [15:0]       subsys_vendor_id,
   output logic [7:0]        cap_ptr
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small for the control word address");
   end
   if (REV_LOAD_W > 8) begin : g_bad_rev
      $error("REV_LOAD_W must not exceed 8");
   end
   if (WORD_W != 16) begin : g_bad_word
      $error("word width must be 16");
   end

   logic [NUM_WORDS*WORD_W-1:0] words;
   logic                        commit;
   logic [WORD_W-1:0]           ctrl_d, sub_id_d, sub_ven_d;
   logic [7:0]                  rev_d;

   id_fetch_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .words(words), .commit(commit)
   );

   id_decode #(.DEF_REV(DEF_REV), .REV_LOAD_W(REV_LOAD_W), .REV_SRC_LSB(8)) u_dec (
      .words(words), .ctrl(ctrl_d), .sub_id(sub_id_d),
      .sub_ven(sub_ven_d), .rev(rev_d)
   );

   id_regs #(.DEF_REV(DEF_REV)) u_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .ctrl_d(ctrl_d), .sub_id_d(sub_id_d), .sub_ven_d(sub_ven_d), .rev_d(rev_d),
      .ctrl_q(ctrl_word), .sub_id_q(subsys_id), .sub_ven_q(subsys_vendor_id),
      .rev_q(revision_id), .done_q(load_done)
   );

   assign cfg_retry = ~load_done;
   assign device_id = DEVICE_ID;
   assign vendor_id = VENDOR_ID;
   assign cap_ptr   = CAP_PTR;
endmodule

// File: rtl/cfg_id_loader_chk.sv
module cfg_id_loader_chk #(
   parameter logic [7:0] DEF_REV = 8'h09
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_req,
   input logic        rd_valid,
   input logic        cfg_retry,
   input logic        load_done,
   input logic [15:0] subsys_id,
   input logic [15:0] subsys_vendor_id,
   input logic [7:0]  revision_id,
   input logic [15:0] ctrl_word
);
   // R4
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   // R2
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R2
   no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !rd_req);

   // R3
   retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> cfg_retry);

   // R10
   defaults_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> (subsys_id == 16'h0 && subsys_vendor_id == 16'h0 &&
                      revision_id == DEF_REV && ctrl_word == 16'h0));

   // R11
   frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> ($stable(subsys_id) && $stable(subsys_vendor_id) &&
                     $stable(revision_id) && $stable(ctrl_word)));
endmodule

bind cfg_id_loader cfg_id_loader_chk #(.DEF_REV(DEF_REV)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
   .cfg_retry(cfg_retry), .load_done(load_done),
   .subsys_id(subsys_id), .subsys_vendor_id(subsys_vendor_id),
   .revision_id(revision_id), .ctrl_word(ctrl_word)
);

// File: tb/test_cfg_id_loader.sv
module test_cfg_id_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req;
   logic [7:0]  rd_addr;
   logic        rd_valid = 1'b0;
   logic [15:0] rd_data = '0;
   logic        cfg_retry, load_done;
   logic [15:0] ctrl_word, device_id, vendor_id, subsys_id, subsys_vendor_id;
   logic [7:0]  revision_id, cap_ptr;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   cfg_id_loader i_cfg_id_loader (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .cfg_retry(cfg_retry),
      .load_done(load_done), .ctrl_word(ctrl_word), .device_id(device_id),
      .vendor_id(vendor_id), .revision_id(revision_id), .subsys_id(subsys_id),
      .subsys_vendor_id(subsys_vendor_id), .cap_ptr(cap_ptr)
   );

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_fixed();
      chk(device_id == 16'h1209, "R8 device_id", device_id, 16'h1209);
      chk(vendor_id == 16'h5A5A, "R8 vendor_id", vendor_id, 16'h5A5A);
      chk(cap_ptr == 8'hDC, "R8 cap_ptr", cap_ptr, 8'hDC);
   endtask

   task automatic run_case(input logic [15:0] wa, input logic [15:0] wb,
                           input logic [15:0] wc, input int lat);
      logic [15:0] mem [3];
      logic        seen;
      logic        pres;
      logic [7:0]  exp_rev;
      mem[0] = wa; mem[1] = wb; mem[2] = wc;
      rst_n = 1'b0;
      rd_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // reset state, sampled before the first active edge
      chk(cfg_retry && !load_done, "R3 retry after reset", {cfg_retry, load_done}, 2'b10);
      chk(subsys_id == 0 && subsys_vendor_id == 0 && revision_id == 8'h09 && ctrl_word == 0,
          "R10 defaults after reset", {subsys_id, revision_id}, {16'h0, 8'h09});
      for (int w = 0; w < 3; w++) begin
         seen = 1'b0;
         for (int t = 0; t < 20 && !seen; t++) begin
            if (rd_req) seen = 1'b1;
            else @(negedge clk);
         end
         chk(seen, "R1 request seen", 32'(seen), 1);
         chk(rd_addr == 8'(8'h0A + w), "R1 address order", rd_addr, 8'(8'h0A + w));
         chk(cfg_retry && !load_done, "R3 retry while loading",
             {cfg_retry, load_done}, 2'b10);
         chk(subsys_id == 0 && revision_id == 8'h09, "R10 no partial load",
             {subsys_id, revision_id}, {16'h0, 8'h09});
         @(negedge clk);
         for (int k = 1; k < lat; k++) begin
            chk(!rd_req, "R2 no request while pending", 32'(rd_req), 0);
            @(negedge clk);
         end
         chk(!rd_req, "R2 no request while pending", 32'(rd_req), 0);
         rd_valid = 1'b1;
         rd_data  = mem[w];
         @(negedge clk);
         rd_valid = 1'b0;
         rd_data  = 16'hDEAD;
      end
      pres    = (wa[15:14] == 2'b01);
      exp_rev = (pres && wa[13]) ? (8'h08 | 8'(wa[10:8])) : 8'h09;
      chk(load_done && !cfg_retry, "R4 R3 done after third word",
          {load_done, cfg_retry}, 2'b10);
      chk(subsys_id == (pres ? wb : 16'h0), pres ? "R6 subsys_id" : "R5 subsys_id",
          subsys_id, pres ? wb : 16'h0);
      chk(subsys_vendor_id == (pres ? wc : 16'h0),
          pres ? "R6 subsys_vendor_id" : "R5 subsys_vendor_id",
          subsys_vendor_id, pres ? wc : 16'h0);
      chk(revision_id == exp_rev, "R7 revision_id", revision_id, exp_rev);
      chk(ctrl_word == wa, "R9 ctrl_word", ctrl_word, wa);
      check_fixed();
      // stray response with nothing pending
      rd_valid = 1'b1;
      rd_data  = ~wb;
      @(negedge clk);
      rd_valid = 1'b0;
      @(negedge clk);
      chk(!rd_req, "R11 R2 no request after stray response", 32'(rd_req), 0);
      chk(subsys_id == (pres ? wb : 16'h0) && subsys_vendor_id == (pres ? wc : 16'h0) &&
          revision_id == exp_rev && ctrl_word == wa && load_done,
          "R11 R4 outputs unchanged by stray response",
          {subsys_id, revision_id}, {(pres ? wb : 16'h0), exp_rev});
   endtask

   initial begin
      int n;
      n = 0;
      check_fixed();
      for (int sig = 0; sig < 4; sig++)
         for (int b13 = 0; b13 < 2; b13++)
            for (int r = 0; r < 8; r++) begin
               run_case({2'(sig), 1'(b13), 2'b10, 3'(r), 8'(8'h3C + n)},
                        16'(16'h1000 + n * 37), 16'(16'hC000 - n * 53), 1 + (n % 3));
               n++;
            end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule